// File: doc/BRIEF.md
# Bridge Grant Timeout and Abort Recovery

Two bridges cross between a fast bus and a slow bus, one for each direction. A circular read dependency can lock both: the downward bridge waits for a slow-bus grant that never comes, while the upward bridge holds the slow bus and waits on a fast-bus transaction that the downward traffic blocks. This block breaks that lock from both sides. A grant watchdog counts the cycles that the downward bridge's slow-bus request has been waiting for a grant. When a configurable window expires, it sends a one-cycle abort across to the upward bridge.

The receiving side tracks whether the upward bridge is serving a slow-bus master and has a transaction outstanding on the fast bus. While it waits, it holds a busy level that keeps the slow bus's own timeout from firing. An abort that arrives in that state makes it answer the slow-bus master with a retry, which forces a new arbitration. In the same cycle it cancels the fast-bus transaction and drops busy. The timed-out bridge keeps its request up and starts counting again, so it can win the arbitration that the retry forces.

Top module: `bridge_abort_ctrl`

## Requirements
- R1: After reset, abort_o, sf_busy_o, sf_ack_o, sf_retry_o and sf_cancel_o are all low.
- R2: A clock edge with fs_req_i high and fs_gnt_i low is a waiting edge. On the k-th consecutive waiting edge, where k is a multiple of WAIT_CYCLES, abort_o goes high for exactly one cycle. At all other times it is low.
- R3: An edge with fs_gnt_i high, or with fs_req_i low, resets the run of waiting edges to zero. No abort follows such an edge.
- R4: While the request stays up with no grant, the count restarts after each abort, so pulses come every WAIT_CYCLES edges.
- R5: With TIMEOUT_EN set to 0, abort_o is never asserted, however long the request waits.
- R6: sf_start_i on an edge where sf_busy_o is low raises sf_busy_o after that edge. sf_busy_o stays high until a completion or an abort ends it. sf_start_i while busy has no effect.
- R7: sf_done_i on an edge while busy gives a one-cycle sf_ack_o pulse after that edge and clears sf_busy_o.
- R8: An abort seen on an edge while busy, with no completion on that edge, gives one-cycle pulses on both sf_retry_o and sf_cancel_o after that edge and clears sf_busy_o.
- R9: An abort that arrives while not busy produces no retry and no cancel.
- R10: When completion and abort fall on the same busy edge, the completion wins: sf_ack_o pulses and no retry or cancel is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_req_i | input | 1 | Downward bridge is requesting the slow bus |
| fs_gnt_i | input | 1 | Slow-bus grant to the downward bridge |
| abort_o | output | 1 | One-cycle abort sent to the upward bridge |
| sf_start_i | input | 1 | Upward bridge accepts a slow-bus master and starts a fast-bus transaction |
| sf_done_i | input | 1 | Outstanding fast-bus transaction completes |
| sf_busy_o | output | 1 | Fast-bus transaction outstanding; holds off the slow-bus timeout |
| sf_ack_o | output | 1 | One-cycle completion answer to the slow-bus master |
| sf_retry_o | output | 1 | One-cycle retry answer to the slow-bus master |
| sf_cancel_o | output | 1 | One-cycle cancel of the outstanding fast-bus transaction |

## Verification
The watchdog is swept over two families of patterns. In the first, the request waits for every length from zero up to three windows and then gets a grant. In the second, the request waits for the same range of lengths and then drops. Together these separate "clears on grant" from "clears on request drop", and they show the pulse at the exact window boundary and the periodic restart. The receiving side is driven through normal completion, an abort-driven retry, an abort while idle, a completion on the same edge as an abort, and a start issued while already busy. A second instance with the timeout disabled sees the same stimulus and must never abort.

// File: rtl/bridge_abort_pkg.sv
package bridge_abort_pkg;

    // Registered state of the abort-receiving side
    typedef struct packed {
        logic busy;
        logic ack;
        logic retry;
        logic cancel;
    } resp_state_t;

    localparam resp_state_t RESP_RESET = '{busy: 1'b0, ack: 1'b0, retry: 1'b0, cancel: 1'b0};

endpackage

// File: rtl/grant_watchdog.sv
module grant_watchdog #(
    parameter int WAIT_CYCLES = 16,
    parameter bit TIMEOUT_EN  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic gnt_i,
    output logic abort_o
);

    localparam int CNT_W = (WAIT_CYCLES > 2) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             abort;
    } wd_state_t;

    wd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.abort = 1'b0;
        if (!TIMEOUT_EN || !req_i || gnt_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt   = '0;
            st_d.abort = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign abort_o = st_q.abort;

    // R2
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);

    // R2
    abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(req_i && !gnt_i));

    // R3
    grant_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_i || !req_i) |=> !abort_o);

    generate
        if (!TIMEOUT_EN) begin : g_off_chk
            // R5
            always_ff @(posedge clk) begin
                if (rst_n) disabled_chk: assert (!abort_o);
            end
        end
    endgenerate

endmodule

// File: rtl/abort_responder.sv
module abort_responder
    import bridge_abort_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic done_i,
    input  logic abort_i,
    output logic busy_o,
    output logic ack_o,
    output logic retry_o,
    output logic cancel_o
);

    resp_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.ack    = 1'b0;
        st_d.retry  = 1'b0;
        st_d.cancel = 1'b0;
        if (!st_q.busy) begin
            st_d.busy = start_i;
        end else if (done_i) begin
            st_d.busy = 1'b0;
            st_d.ack  = 1'b1;
        end else if (abort_i) begin
            st_d.busy   = 1'b0;
            st_d.retry  = 1'b1;
            st_d.cancel = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESP_RESET;
        else        st_q <= st_d;
    end

    assign busy_o   = st_q.busy;
    assign ack_o    = st_q.ack;
    assign retry_o  = st_q.retry;
    assign cancel_o = st_q.cancel;

    // R6
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_i && !abort_i) |=> busy_o);

    // R7
    ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && done_i) |=> (ack_o && !busy_o));

    // R8
    retry_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && abort_i && !done_i) |=> (retry_o && cancel_o && !busy_o));

    // R9
    idle_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> (!retry_o && !cancel_o));

    // R10
    ack_retry_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_o && retry_o));

endmodule

// File: rtl/bridge_abort_ctrl.sv
module bridge_abort_ctrl #(
    parameter int WAIT_CYCLES = 16,
    parameter bit TIMEOUT_EN  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_req_i,
    input  logic fs_gnt_i,
    output logic abort_o,
    input  logic sf_start_i,
    input  logic sf_done_i,
    output logic sf_busy_o,
    output logic sf_ack_o,
    output logic sf_retry_o,
    output logic sf_cancel_o
);

    logic abort_w;

    grant_watchdog #(
        .WAIT_CYCLES(WAIT_CYCLES),
        .TIMEOUT_EN (TIMEOUT_EN)
    ) i_watchdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (fs_req_i),
        .gnt_i  (fs_gnt_i),
        .abort_o(abort_w)
    );

    abort_responder i_responder (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sf_start_i),
        .done_i  (sf_done_i),
        .abort_i (abort_w),
        .busy_o  (sf_busy_o),
        .ack_o   (sf_ack_o),
        .retry_o (sf_retry_o),
        .cancel_o(sf_cancel_o)
    );

    assign abort_o = abort_w;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !(abort_o || sf_busy_o || sf_ack_o || sf_retry_o || sf_cancel_o));

endmodule

// File: tb/test_bridge_abort_ctrl.sv
module test_bridge_abort_ctrl;

    localparam int W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, gnt = 1'b0, start = 1'b0, done = 1'b0;
    logic abort, busy, ack, retry, cancel;
    logic abort_off, busy_off, ack_off, retry_off, cancel_off;

    int n_chk = 0;
    int n_fail = 0;

    // bench model
    int   run = 0;
    logic e_abort = 0, e_busy = 0, e_ack = 0, e_retry = 0;

    always #2 clk = ~clk;

    bridge_abort_ctrl #(.WAIT_CYCLES(W), .TIMEOUT_EN(1'b1)) i_bridge_abort_ctrl (
        .clk(clk), .rst_n(rst_n), .fs_req_i(req), .fs_gnt_i(gnt), .abort_o(abort),
        .sf_start_i(start), .sf_done_i(done), .sf_busy_o(busy), .sf_ack_o(ack),
        .sf_retry_o(retry), .sf_cancel_o(cancel));

    bridge_abort_ctrl #(.WAIT_CYCLES(W), .TIMEOUT_EN(1'b0)) i_bridge_abort_ctrl_off (
        .clk(clk), .rst_n(rst_n), .fs_req_i(req), .fs_gnt_i(gnt), .abort_o(abort_off),
        .sf_start_i(start), .sf_done_i(done), .sf_busy_o(busy_off), .sf_ack_o(ack_off),
        .sf_retry_o(retry_off), .sf_cancel_o(cancel_off));

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, update model at posedge, check 1 ns later
    task automatic step(input logic r, input logic g, input logic s, input logic d, input string tag);
        logic prev_abort;
        @(negedge clk);
        req = r; gnt = g; start = s; done = d;
        @(posedge clk);
        prev_abort = e_abort;
        run     = (r && !g) ? run + 1 : 0;
        e_abort = (run > 0) && (run % W == 0);
        e_ack   = e_busy && d;
        e_retry = e_busy && !d && prev_abort;
        e_busy  = e_busy ? !(d || prev_abort) : s;
        #1;
        chk(tag, "abort", abort, e_abort);
        chk(tag, "busy", busy, e_busy);
        chk(tag, "ack", ack, e_ack);
        chk(tag, "retry", retry, e_retry);
        chk(tag, "cancel", cancel, e_retry);
        chk("R5", "abort_off", abort_off, 1'b0);
        chk("R5", "retry_off", retry_off, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: run did not end, actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "abort", abort, 1'b0);
        chk("R1", "busy", busy, 1'b0);
        chk("R1", "ack", ack, 1'b0);
        chk("R1", "retry", retry, 1'b0);
        chk("R1", "cancel", cancel, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4: grant after g waiting edges
        for (int g = 0; g <= 3 * W; g++) begin
            for (int i = 0; i < g; i++) step(1, 0, 0, 0, "R2_R4");
            step(1, 1, 0, 0, "R3_grant");
            step(1, 0, 0, 0, "R3_restart");
            step(0, 0, 0, 0, "R3_idle");
        end
        // R3: request drops after g waiting edges
        for (int g = 1; g <= 3 * W; g++) begin
            for (int i = 0; i < g; i++) step(1, 0, 0, 0, "R2_R4");
            step(0, 0, 0, 0, "R3_drop");
        end

        // R6 R7: normal completion, start while busy ignored
        step(0, 0, 1, 0, "R6_start");
        step(0, 0, 1, 0, "R6_start_busy");
        step(0, 0, 0, 0, "R6_hold");
        step(0, 0, 0, 1, "R7_done");
        step(0, 0, 0, 0, "R7_after");

        // R8: abort while busy gives retry and cancel
        step(0, 0, 1, 0, "R8_start");
        for (int i = 0; i < W; i++) step(1, 0, 0, 0, "R8_wait");
        step(1, 0, 0, 0, "R8_retry");
        step(1, 0, 0, 0, "R8_after");
        step(0, 0, 0, 0, "R8_idle");

        // R9: abort while idle ignored
        for (int i = 0; i < W + 2; i++) step(1, 0, 0, 0, "R9_idle_abort");
        step(0, 0, 0, 0, "R9_idle");

        // R10: completion on the same edge as the abort wins
        step(0, 0, 1, 0, "R10_start");
        for (int i = 0; i < W; i++) step(1, 0, 0, 0, "R10_wait");
        step(0, 0, 0, 1, "R10_both");
        step(0, 0, 0, 0, "R10_after");

        // R5: long wait on the disabled instance
        for (int i = 0; i < 4 * W; i++) step(1, 0, 0, 0, "R5_long");
        step(0, 0, 0, 0, "R5_end");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule